// File: doc/BRIEF.md
# Immediate-Placing Integer ALU

This block is the integer execution unit of a small RISC core. Each operation takes a first register operand and either a second register operand or a 16-bit immediate. It produces a 32-bit result without any clock delay. A 3-bit sub-opcode picks one of eight functions: add, add with carry, subtract, subtract with borrow, AND, OR, XOR and shift.

In immediate form, a high-half select bit places the immediate in the lower or the upper half-word. AND fills the other half with ones, so that half of the source register passes through unchanged. All other operations fill the other half with zeros.

Shifts use a signed count. A positive count shifts left and a negative count shifts right, so one encoding covers both directions. A status register holds four condition flags. It is written on a clock edge only when the operation is valid and asks for a flag update. The carry and borrow variants read its carry bit.

Top module: `imm_alu`

## Requirements
- R1: With `use_imm_i`=0, `sub_op_i` selects the operation applied to `src_a_i` and `src_b_i`: 000 add, 010 subtract (a minus b), 100 AND, 101 OR, 110 XOR. `result_o` follows the inputs combinationally.
- R2: With `use_imm_i`=1, the second operand is built from `imm_i`. When `high_half_i`=0 the immediate sits in bits 15..0; when `high_half_i`=1 it sits in bits 31..16. For add, subtract, OR and XOR the remaining half is zero.
- R3: For AND in immediate form, the remaining half of the operand is all ones, so the matching half of `src_a_i` appears unchanged in `result_o`.
- R4: Sub-op 001 computes a+b+C. Sub-op 011 computes a-b-(1-C). C is the stored carry flag.
- R5: The flags in `flags_o` change only at a rising clock edge where `valid_i`=1 and `set_flags_i`=1. Otherwise they hold their value.
- R6: The flag encoding is `flags_o[3]`=N, `[2]`=Z, `[1]`=C, `[0]`=V. On an update, N takes bit 31 of the result and Z is set when the result is zero.
- R7: For add variants, C is the carry out. For subtract variants, C is the inverted borrow (1 when no borrow occurs). V is signed overflow. For AND, OR and XOR, C and V are cleared.
- R8: Sub-op 111 in immediate form shifts by the signed count `imm_i[5:0]` (range -31..+31). A positive count shifts left and a negative count shifts right by its magnitude. `high_half_i`=0 selects a logical shift and 1 selects an arithmetic shift.
- R9: Sub-op 111 in register form takes its signed count from `src_b_i[5:0]`. `func_i`=11000 selects an arithmetic shift and any other value (normally 10000) selects a logical shift. A count of -32 gives zero for a logical shift and a copy of bit 31 in every position for an arithmetic shift.
- R10: For shifts, C becomes the last bit shifted out, or 0 when the count is zero. V is cleared.
- R11: After reset, `flags_o` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation present this cycle |
| use_imm_i | input | 1 | 1 selects register-immediate form |
| sub_op_i | input | 3 | Operation select |
| high_half_i | input | 1 | Immediate half select; shift kind in immediate form |
| set_flags_i | input | 1 | Request a flag update |
| func_i | input | 5 | Shift kind in register form |
| src_a_i | input | 32 | First register operand |
| src_b_i | input | 32 | Second register operand or shift count |
| imm_i | input | 16 | Immediate field |
| result_o | output | 32 | Combinational result |
| flags_o | output | 4 | Status flags {N,Z,C,V} |

## Verification
The result is due in the same cycle as its inputs. The bench drives each operation at the falling edge and compares `result_o` with its reference model a short settling delay later, before the next rising edge. The flags are due one rising edge after the operation that writes them. The model therefore updates its flag copy only after that edge, and the comparison of `flags_o` takes place at the following falling edge. Long stretches of random operations let carries set by one operation feed the carry and borrow variants that come after it.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_ADDC = 3'b001,
    OP_SUB  = 3'b010,
    OP_SUBB = 3'b011,
    OP_AND  = 3'b100,
    OP_OR   = 3'b101,
    OP_XOR  = 3'b110,
    OP_SHF  = 3'b111
  } subop_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam logic [4:0] SHF_ARITH_CODE = 5'b11000;
endpackage

// File: rtl/ialu_operand.sv
module ialu_operand
  import ialu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 6
) (
  input  logic                    use_imm,
  input  logic                    high_half,
  input  subop_e                  op,
  input  logic [W/2-1:0]          imm,
  input  logic [W-1:0]            src_b,
  output logic [W-1:0]            opnd_b,
  output logic signed [AMT_W-1:0] shamt
);
  localparam int HALF = W / 2;

  logic [HALF-1:0] fill;

  always_comb begin
    fill = (op == OP_AND) ? {HALF{1'b1}} : {HALF{1'b0}};
    if (!use_imm)      opnd_b = src_b;
    else if (high_half) opnd_b = {imm, fill};
    else               opnd_b = {fill, imm};
    shamt = use_imm ? $signed(imm[AMT_W-1:0]) : $signed(src_b[AMT_W-1:0]);
  end
endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter #(
  parameter int W     = 32,
  parameter int AMT_W = 6
) (
  input  logic [W-1:0]            a,
  input  logic signed [AMT_W-1:0] shamt,
  input  logic                    arith,
  output logic [W-1:0]            res,
  output logic                    cout
);
  // returns {last bit out, result}
  function automatic logic [W:0] shift_fn(input logic [W-1:0] val,
                                          input logic signed [AMT_W-1:0] cnt,
                                          input logic ar);
    logic signed [AMT_W:0] ext;
    logic [AMT_W:0]        mag;
    logic [W:0]            t;
    ext = AMT_W'(cnt);
    ext = {cnt[AMT_W-1], cnt};
    mag = ext[AMT_W] ? (AMT_W+1)'(-ext) : (AMT_W+1)'(ext);
    if (!ext[AMT_W]) begin
      t = {1'b0, val} << mag;
      shift_fn = {(mag != 0) & t[W], t[W-1:0]};
    end else begin
      t = {val, 1'b0};
      if (ar) t = $unsigned($signed(t) >>> mag);
      else    t = t >> mag;
      shift_fn = {t[0], t[W:1]};
    end
  endfunction

  always_comb begin
    {cout, res} = shift_fn(a, shamt, arith);
  end
endmodule

// File: rtl/ialu_arith.sv
module ialu_arith
  import ialu_pkg::*;
#(
  parameter int W = 32
) (
  input  subop_e       op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         c_out,
  output logic         v_out
);
  // {carry, sum} of a + b + ci
  function automatic logic [W:0] add_fn(input logic [W-1:0] x,
                                        input logic [W-1:0] y,
                                        input logic ci);
    add_fn = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  endfunction

  logic [W:0]   sum;
  logic [W-1:0] b_eff;
  logic         ci;
  logic         is_sub;

  always_comb begin
    is_sub = (op == OP_SUB) || (op == OP_SUBB);
    b_eff  = is_sub ? ~b : b;
    case (op)
      OP_ADDC: ci = c_in;
      OP_SUB:  ci = 1'b1;
      OP_SUBB: ci = c_in;
      default: ci = 1'b0;
    endcase
    sum   = add_fn(a, b_eff, ci);
    c_out = 1'b0;
    v_out = 1'b0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      default: begin
        res   = sum[W-1:0];
        c_out = sum[W];
        v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
      end
    endcase
  end
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import ialu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AMT_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid_i,
  input  logic           use_imm_i,
  input  logic [2:0]     sub_op_i,
  input  logic           high_half_i,
  input  logic           set_flags_i,
  input  logic [4:0]     func_i,
  input  logic [W-1:0]   src_a_i,
  input  logic [W-1:0]   src_b_i,
  input  logic [W/2-1:0] imm_i,
  output logic [W-1:0]   result_o,
  output logic [3:0]     flags_o
);
  subop_e                  op;
  logic [W-1:0]            opnd_b;
  logic signed [AMT_W-1:0] shamt;
  logic                    shf_arith;
  logic [W-1:0]            sh_res;
  logic                    sh_c;
  logic [W-1:0]            ar_res;
  logic                    ar_c;
  logic                    ar_v;
  logic                    is_shift;
  logic                    flag_we;
  flags_t                  flags_q;
  flags_t                  flags_nxt;

  assign op        = subop_e'(sub_op_i);
  assign is_shift  = (op == OP_SHF);
  assign shf_arith = use_imm_i ? high_half_i : (func_i == SHF_ARITH_CODE);

  ialu_operand #(.W(W), .AMT_W(AMT_W)) u_opnd (
    .use_imm   (use_imm_i),
    .high_half (high_half_i),
    .op        (op),
    .imm       (imm_i),
    .src_b     (src_b_i),
    .opnd_b    (opnd_b),
    .shamt     (shamt)
  );

  ialu_shifter #(.W(W), .AMT_W(AMT_W)) u_shf (
    .a     (src_a_i),
    .shamt (shamt),
    .arith (shf_arith),
    .res   (sh_res),
    .cout  (sh_c)
  );

  ialu_arith #(.W(W)) u_ar (
    .op    (op),
    .a     (src_a_i),
    .b     (opnd_b),
    .c_in  (flags_q.c),
    .res   (ar_res),
    .c_out (ar_c),
    .v_out (ar_v)
  );

  assign result_o = is_shift ? sh_res : ar_res;
  assign flag_we  = valid_i & set_flags_i;

  always_comb begin
    flags_nxt.n = result_o[W-1];
    flags_nxt.z = (result_o == '0);
    flags_nxt.c = is_shift ? sh_c : ar_c;
    flags_nxt.v = is_shift ? 1'b0 : ar_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= flags_nxt;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/imm_alu_chk.sv
module imm_alu_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           valid_i,
  input logic           use_imm_i,
  input logic [2:0]     sub_op_i,
  input logic           high_half_i,
  input logic           set_flags_i,
  input logic [W-1:0]   src_a_i,
  input logic [W-1:0]   result_o,
  input logic [3:0]     flags_o
);
  localparam int HALF = W / 2;

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_i && set_flags_i) |=> $stable(flags_o));

  a_r6_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_flags_i) |=> (flags_o[2] == ($past(result_o) == '0)));

  a_r6_neg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_flags_i) |=> (flags_o[3] == $past(result_o[W-1])));

  a_r7_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && set_flags_i && sub_op_i[2] && (sub_op_i != 3'b111))
      |=> (flags_o[1:0] == 2'b00));

  a_r3_and_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && (sub_op_i == 3'b100) && !high_half_i)
      |-> (result_o[W-1:HALF] == src_a_i[W-1:HALF]));

  a_r3_and_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && (sub_op_i == 3'b100) && high_half_i)
      |-> (result_o[HALF-1:0] == src_a_i[HALF-1:0]));

  a_r2_or_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm_i && (sub_op_i == 3'b101) && high_half_i)
      |-> (result_o[HALF-1:0] == src_a_i[HALF-1:0]));
endmodule

bind imm_alu imm_alu_chk #(.W(W)) u_chk (.*);

// File: tb/sim_imm_alu.sv
module sim_imm_alu;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic        use_imm_i = 1'b0;
  logic [2:0]  sub_op_i = 3'b000;
  logic        high_half_i = 1'b0;
  logic        set_flags_i = 1'b0;
  logic [4:0]  func_i = 5'b10000;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int compared = 0;
  int mismatched = 0;
  logic [3:0] mflags = 4'b0000;
  string prev_tag = "R11";

  always #2 clk = ~clk;

  imm_alu u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .use_imm_i(use_imm_i),
    .sub_op_i(sub_op_i), .high_half_i(high_half_i), .set_flags_i(set_flags_i),
    .func_i(func_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  // behavioural reference: returns result, fills flag candidate
  task automatic model(input logic ui, input logic [2:0] op, input logic h,
                       input logic [4:0] fn, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] im,
                       output logic [31:0] r, output logic [3:0] nf);
    logic [31:0] bo;
    logic c, v;
    longint s, ss;
    int k;
    logic ar;
    if (!ui) bo = b;
    else begin
      bo = (op == 3'b100) ? 32'hFFFF_FFFF : 32'h0;
      if (h) bo[31:16] = im; else bo[15:0] = im;
    end
    c = 1'b0; v = 1'b0; r = '0;
    case (op)
      3'b000, 3'b001: begin
        s  = longint'(a) + longint'(bo) + ((op == 3'b001) ? longint'(mflags[1]) : 0);
        ss = longint'($signed(a)) + longint'($signed(bo)) + ((op == 3'b001) ? longint'(mflags[1]) : 0);
        r = s[31:0]; c = (s >= 64'sh1_0000_0000);
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'b010, 3'b011: begin
        s  = longint'(a) - longint'(bo) - ((op == 3'b011) ? longint'(!mflags[1]) : 0);
        ss = longint'($signed(a)) - longint'($signed(bo)) - ((op == 3'b011) ? longint'(!mflags[1]) : 0);
        r = s[31:0]; c = (s >= 0);
        v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
      end
      3'b100: r = a & bo;
      3'b101: r = a | bo;
      3'b110: r = a ^ bo;
      default: begin
        k = ui ? int'($signed(im[5:0])) : int'($signed(b[5:0]));
        ar = ui ? h : (fn == 5'b11000);
        r = a;
        for (int i = 0; i < k; i++) begin c = r[31]; r = r << 1; end
        for (int i = 0; i < -k; i++) begin
          c = r[0]; r = {ar & r[31], r[31:1]};
        end
      end
    endcase
    nf = {r[31], (r == 32'h0), c, v};
  endtask

  task automatic apply(string tag, logic vld, logic ui, logic [2:0] op, logic h,
                       logic f, logic [4:0] fn, logic [31:0] a, logic [31:0] b,
                       logic [15:0] im);
    logic [31:0] er;
    logic [3:0]  ef;
    @(negedge clk);
    valid_i = vld; use_imm_i = ui; sub_op_i = op; high_half_i = h;
    set_flags_i = f; func_i = fn; src_a_i = a; src_b_i = b; imm_i = im;
    #1;
    model(ui, op, h, fn, a, b, im, er, ef);
    check(tag, "result", result_o, er);
    check(prev_tag, "flags", {28'h0, flags_o}, {28'h0, mflags});
    @(posedge clk);
    if (vld && f) mflags = ef;
    prev_tag = tag;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11", "reset flags", {28'h0, flags_o}, 32'h0);
    @(negedge clk) rst_n = 1'b1;
    // R1 register forms
    apply("R1", 1, 0, 3'b000, 0, 1, 5'b10000, 32'd5, 32'd7, 16'h0);
    apply("R7", 1, 0, 3'b000, 0, 1, 5'b10000, 32'hFFFF_FFFF, 32'd1, 16'h0);
    apply("R4", 1, 0, 3'b001, 0, 0, 5'b10000, 32'd1, 32'd1, 16'h0);
    apply("R1", 1, 0, 3'b010, 0, 1, 5'b10000, 32'd5, 32'd7, 16'h0);
    apply("R4", 1, 0, 3'b011, 0, 0, 5'b10000, 32'd10, 32'd3, 16'h0);
    apply("R1", 1, 0, 3'b100, 0, 0, 5'b10000, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    apply("R1", 1, 0, 3'b101, 0, 0, 5'b10000, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    apply("R1", 1, 0, 3'b110, 0, 0, 5'b10000, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0);
    // R7 overflow, then logic clears C/V
    apply("R7", 1, 0, 3'b000, 0, 1, 5'b10000, 32'h7FFF_FFFF, 32'd1, 16'h0);
    apply("R7", 1, 0, 3'b110, 0, 1, 5'b10000, 32'h8000_0000, 32'h0, 16'h0);
    // R5: flag request without valid is ignored
    apply("R5", 1, 0, 3'b010, 0, 1, 5'b10000, 32'd1, 32'd2, 16'h0);
    apply("R5", 0, 0, 3'b000, 0, 1, 5'b10000, 32'd0, 32'd0, 16'h0);
    apply("R5", 1, 0, 3'b000, 0, 0, 5'b10000, 32'd0, 32'd0, 16'h0);
    // R2 immediate placement
    apply("R2", 1, 1, 3'b000, 0, 0, 5'b10000, 32'h1000_0000, 32'h0, 16'hABCD);
    apply("R2", 1, 1, 3'b000, 1, 0, 5'b10000, 32'h0000_1111, 32'h0, 16'h0002);
    apply("R2", 1, 1, 3'b101, 1, 0, 5'b10000, 32'h1234_5678, 32'h0, 16'hF000);
    apply("R2", 1, 1, 3'b010, 1, 1, 5'b10000, 32'h0001_0000, 32'h0, 16'h0001);
    // R3 AND ones fill
    apply("R3", 1, 1, 3'b100, 0, 0, 5'b10000, 32'h1234_5678, 32'h0, 16'h00F0);
    apply("R3", 1, 1, 3'b100, 1, 0, 5'b10000, 32'h1234_5678, 32'h0, 16'h0F00);
    // R8 immediate shifts
    apply("R8", 1, 1, 3'b111, 0, 1, 5'b10000, 32'h8000_0001, 32'h0, 16'd4);
    apply("R8", 1, 1, 3'b111, 0, 1, 5'b10000, 32'h8000_0000, 32'h0, 16'hFFFC);
    apply("R8", 1, 1, 3'b111, 1, 1, 5'b10000, 32'h8000_0008, 32'h0, 16'hFFFC);
    apply("R10", 1, 1, 3'b111, 0, 1, 5'b10000, 32'hFFFF_FFFF, 32'h0, 16'h0);
    apply("R8", 1, 1, 3'b111, 1, 1, 5'b10000, 32'h8000_0000, 32'h0, 16'hFFE1);
    // R9 register shifts
    apply("R9", 1, 0, 3'b111, 0, 1, 5'b10000, 32'h0000_00F0, 32'hFFFF_FFFF, 16'h0);
    apply("R9", 1, 0, 3'b111, 0, 1, 5'b10000, 32'h8000_1234, 32'h0000_0020, 16'h0);
    apply("R9", 1, 0, 3'b111, 0, 1, 5'b11000, 32'h8000_1234, 32'h0000_0020, 16'h0);
    apply("R9", 1, 0, 3'b111, 0, 1, 5'b11000, 32'h4000_0000, 32'hFFFF_FFC0, 16'h0);
    apply("R10", 1, 0, 3'b111, 0, 1, 5'b10000, 32'h4000_0000, 32'h0000_001F, 16'h0);
    // R6 zero result
    apply("R6", 1, 0, 3'b010, 0, 1, 5'b10000, 32'h55, 32'h55, 16'h0);
    apply("R6", 1, 0, 3'b000, 0, 0, 5'b10000, 32'h0, 32'h0, 16'h0);
    // random mix; carry chains across operations
    for (int n = 0; n < 600; n++) begin
      logic [2:0] rop;
      logic ru;
      rop = 3'($urandom_range(0, 7));
      ru  = 1'($urandom_range(0, 1));
      apply(ru ? "R2" : "R1", ($urandom_range(0, 9) != 0), ru, rop,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 1) != 0) ? 5'b11000 : 5'b10000,
            $urandom(), $urandom(),
            (ru && rop == 3'b111) ? 16'($signed(6'($urandom_range(0, 62)) - 6'd31)) : 16'($urandom()));
    end
    apply("R5", 0, 0, 3'b000, 0, 0, 5'b10000, 32'h0, 32'h0, 16'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule